// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This block shifts a 32-bit destination word left or right. The bit positions that the shift empties are filled from a second source word, not with zeros. The unit joins the two words into one 64-bit pair and shifts the pair. It returns only the slice that lands in the destination's width.

The count comes from one of two places: an 8-bit immediate or an 8-bit count register. A select input picks which one. Only the low five bits of the chosen count matter.

Along with the result, the block produces:
- the six arithmetic flags (carry, parity, auxiliary, zero, sign, overflow);
- an enable that tells the surrounding pipeline whether those flags should be committed.

When the masked count is zero, the destination passes through unchanged and no flag is touched. The result is registered one clock after the request and is tagged with a valid bit.

Top module: `funnel_shift32`

## Requirements
- R1: The effective count is the low 5 bits of `imm_cnt` when `use_imm` is 1, and of `reg_cnt` when `use_imm` is 0; bits 7..5 of either count have no effect.
- R2: With an effective count of 0, `result` equals the destination word, `flag_we` is 0 and all six flag outputs keep their previous values.
- R3: For a left shift (`dir_right`=0) by n, `result` is (dst << n) | (src >> (32-n)).
- R4: For a right shift (`dir_right`=1) by n, `result` is (src << (32-n)) | (dst >> n).
- R5: With a nonzero count, `f_cf` is the last destination bit shifted out: dst[32-n] for left, dst[n-1] for right.
- R6: With a nonzero count, `f_of` is 1 exactly when result bit 31 differs from destination bit 31.
- R7: With a nonzero count, `f_sf` equals result bit 31 and `f_zf` is 1 exactly when the result is all zeros.
- R8: With a nonzero count, `f_pf` is 1 when result bits 7..0 hold an even number of ones; `f_af` is always 0.
- R9: `out_valid` and `flag_we` follow a request (`in_valid`=1) by exactly one clock. `result` changes only on a request, and the flags change only when `flag_we` rises with them.
- R10: While `rst_n` is 0, `out_valid`, `flag_we`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe for this cycle's operands |
| dst_word | input | 32 | Destination operand (the slice returned) |
| src_word | input | 32 | Fill operand supplying vacated bits |
| dir_right | input | 1 | 1 = shift right, 0 = shift left |
| use_imm | input | 1 | 1 = count from imm_cnt, 0 = from reg_cnt |
| imm_cnt | input | 8 | Immediate count |
| reg_cnt | input | 8 | Count register value |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 32 | Shifted destination slice |
| flag_we | output | 1 | Flags should be committed (nonzero count) |
| f_cf | output | 1 | Carry flag |
| f_pf | output | 1 | Parity flag |
| f_af | output | 1 | Auxiliary flag |
| f_zf | output | 1 | Zero flag |
| f_sf | output | 1 | Sign flag |
| f_of | output | 1 | Overflow flag |

## Verification
The assertions assume the following about the inputs:
- the destination word and the count fields are known whenever `in_valid` is high;
- reset is held low for at least one rising edge before the first request.

Their `$past` terms therefore relate each output to the operands of the previous cycle's request. The stimulus always drives fully defined operands. It changes inputs only on the falling edge. It keeps `in_valid` low throughout reset. It mixes back-to-back requests with idle cycles, so the hold behaviour is observed as well as the update behaviour.

// File: rtl/funnel_shift32.sv
module funnel_shift32 #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] dst_word,
  input  logic [WIDTH-1:0] src_word,
  input  logic             dir_right,
  input  logic             use_imm,
  input  logic [CNT_W-1:0] imm_cnt,
  input  logic [CNT_W-1:0] reg_cnt,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             flag_we,
  output logic             f_cf,
  output logic             f_pf,
  output logic             f_af,
  output logic             f_zf,
  output logic             f_sf,
  output logic             f_of
);
  localparam int CW = $clog2(WIDTH);

  logic [CW-1:0]        n, nm1;
  logic [2*WIDTH-1:0]   lcat, rcat;
  logic [WIDTH-1:0]     shifted, dl, dr;
  logic                 carry, nz;

  assign n       = use_imm ? imm_cnt[CW-1:0] : reg_cnt[CW-1:0];
  assign nz      = |n;
  assign nm1     = n - 1'b1;
  assign lcat    = {dst_word, src_word} << n;
  assign rcat    = {src_word, dst_word} >> n;
  assign shifted = dir_right ? rcat[WIDTH-1:0] : lcat[2*WIDTH-1:WIDTH];
  assign dl      = dst_word << nm1;
  assign dr      = dst_word >> nm1;
  assign carry   = dir_right ? dr[0] : dl[WIDTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flag_we   <= 1'b0;
      result    <= '0;
      f_cf      <= 1'b0;
      f_pf      <= 1'b0;
      f_af      <= 1'b0;
      f_zf      <= 1'b0;
      f_sf      <= 1'b0;
      f_of      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      flag_we   <= in_valid && nz;
      if (in_valid) result <= shifted;
      if (in_valid && nz) begin
        f_cf <= carry;
        f_pf <= ~^shifted[7:0];
        f_af <= 1'b0;
        f_zf <= ~|shifted;
        f_sf <= shifted[WIDTH-1];
        f_of <= shifted[WIDTH-1] ^ dst_word[WIDTH-1];
      end
    end
  end

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_we_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> out_valid);
  assert_zero_count_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nz) |=> (result == $past(dst_word)) && !flag_we);
  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |-> $stable({f_cf, f_pf, f_af, f_zf, f_sf, f_of}));
  assert_overflow_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> f_of == (result[WIDTH-1] ^ $past(dst_word[WIDTH-1])));
  assert_sign_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (f_sf == result[WIDTH-1]) && (f_zf == (result == '0)));
  assert_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> f_pf == ~^result[7:0]);
  assert_aux_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !f_af);
endmodule

// File: tb/test_funnel_shift32.sv
module test_funnel_shift32;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] dst_word = '0, src_word = '0;
  logic        dir_right = 1'b0, use_imm = 1'b0;
  logic [7:0]  imm_cnt = '0, reg_cnt = '0;
  logic        out_valid, flag_we, f_cf, f_pf, f_af, f_zf, f_sf, f_of;
  logic [31:0] result;

  int checks = 0, fails = 0;
  bit e_valid = 0, e_we = 0, e_cf = 0, e_pf = 0, e_zf = 0, e_sf = 0, e_of = 0;
  logic [31:0] e_res = '0;
  string res_tag = "R9";

  funnel_shift32 i_funnel_shift32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_word(dst_word),
    .src_word(src_word), .dir_right(dir_right), .use_imm(use_imm),
    .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .out_valid(out_valid),
    .result(result), .flag_we(flag_we), .f_cf(f_cf), .f_pf(f_pf),
    .f_af(f_af), .f_zf(f_zf), .f_sf(f_sf), .f_of(f_of));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R9 out_valid", 32'(out_valid), 32'(e_valid));
    chk("R9 flag_we", 32'(flag_we), 32'(e_we));
    chk(res_tag, result, e_res);
    chk("R5 carry", 32'(f_cf), 32'(e_cf));
    chk("R6 overflow", 32'(f_of), 32'(e_of));
    chk("R7 sign", 32'(f_sf), 32'(e_sf));
    chk("R7 zero", 32'(f_zf), 32'(e_zf));
    chk("R8 parity", 32'(f_pf), 32'(e_pf));
    chk("R8 aux", 32'(f_af), 32'd0);
  endtask

  // one clock: drive on falling edge, update model, compare after rising edge
  task automatic step(bit v, logic [31:0] d, logic [31:0] s, bit rgt, bit imm,
                      logic [7:0] ic, logic [7:0] rc, string tag);
    int n, ones;
    logic [31:0] r;
    @(negedge clk);
    in_valid = v; dst_word = d; src_word = s; dir_right = rgt;
    use_imm = imm; imm_cnt = ic; reg_cnt = rc;
    n = imm ? (int'(ic) % 32) : (int'(rc) % 32);
    e_valid = v;
    e_we = v && (n != 0);
    if (v) begin
      for (int k = 0; k < 32; k++) begin
        if (!rgt) r[k] = (k >= n) ? d[k-n] : s[32+k-n];
        else      r[k] = (k + n < 32) ? d[k+n] : s[k+n-32];
      end
      e_res = r;
      res_tag = tag;
      if (n != 0) begin
        e_cf = rgt ? d[n-1] : d[32-n];
        e_of = r[31] != d[31];
        e_sf = r[31];
        e_zf = (r == 0);
        ones = 0;
        for (int k = 0; k < 8; k++) ones += int'(r[k]);
        e_pf = (ones % 2) == 0;
      end
    end
    @(posedge clk);
    #(PERIOD/4);
    compare_all();
  endtask

  initial begin
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    // R10 reset state
    chk("R10 out_valid", 32'(out_valid), 0);
    chk("R10 flag_we", 32'(flag_we), 0);
    chk("R10 result", result, 0);
    chk("R10 flags", 32'({f_cf, f_pf, f_af, f_zf, f_sf, f_of}), 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    // R3 left shifts
    step(1, 32'h8000_0001, 32'hF000_0000, 0, 1, 8'd4, 8'd0, "R3 left by 4");
    step(1, 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 8'd0, 8'd1, "R3 left by 1");
    step(1, 32'h0000_0001, 32'hFFFF_FFFF, 0, 1, 8'd31, 8'd0, "R3 left by 31");
    // R4 right shifts
    step(1, 32'h8000_0001, 32'h0000_000F, 1, 1, 8'd4, 8'd0, "R4 right by 4");
    step(1, 32'hFFFF_FFFF, 32'h0000_0000, 1, 0, 8'd0, 8'd31, "R4 right by 31");
    // R7 zero result
    step(1, 32'h0000_0001, 32'h0000_0000, 1, 1, 8'd1, 8'd0, "R7 zero result");
    // R2 zero count: flags must hold, idle gap between
    step(1, 32'hDEAD_BEEF, 32'h1111_1111, 0, 1, 8'd0, 8'd9, "R2 zero count imm");
    step(0, 32'h0, 32'h0, 0, 0, 0, 0, "R2 idle");
    step(1, 32'hCAFE_F00D, 32'h2222_2222, 1, 0, 8'd3, 8'd64, "R2 zero count masked reg");
    // R1 masking and source select
    step(1, 32'h0F0F_0F0F, 32'hA5A5_A5A5, 0, 1, 8'd37, 8'd2, "R1 imm 37 masks to 5");
    step(1, 32'h0F0F_0F0F, 32'hA5A5_A5A5, 1, 0, 8'd2, 8'hE3, "R1 reg 0xE3 masks to 3");
    step(1, 32'h0F0F_0F0F, 32'hA5A5_A5A5, 1, 1, 8'd32, 8'd7, "R1 imm 32 masks to 0");
    // R9 hold across idle cycles
    step(0, 32'h5555_5555, 32'h6666_6666, 0, 1, 8'd5, 8'd5, "R9 idle hold");
    step(0, 32'h7777_7777, 32'h8888_8888, 1, 1, 8'd5, 8'd5, "R9 idle hold");
    // pseudo-random mix, back-to-back and gapped
    for (int t = 0; t < 400; t++) begin
      bit rgt = 1'($urandom);
      step(($urandom % 4) != 0, $urandom, $urandom, rgt, 1'($urandom),
           8'($urandom), 8'($urandom), rgt ? "R4 random" : "R3 random");
    end
    // R10 reset in mid-stream
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(posedge clk); #(PERIOD/4);
    chk("R10 out_valid after reset", 32'(out_valid), 0);
    chk("R10 result after reset", result, 0);
    chk("R10 flags after reset", 32'({f_cf, f_pf, f_af, f_zf, f_sf, f_of}), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule